// File: doc/BRIEF.md
# Stereo Soft Mute with Raised-Cosine Gain Ramp

This block sits in a stereo digital audio stream and fades the signal between full level and silence whenever a mute is requested or withdrawn. The fade is not a straight line and not a hard cut. The gain follows a raised-cosine curve of 32 steps, and the curve moves one step for every stereo sample pair that passes through. The same gain is applied to the left and right channels. Each sample is multiplied as a signed value by the gain and truncated back to the input width.

Three sources can request a mute: a dedicated mute pin, a control register bit, and loss of lock reported by the upstream input decoder. A bypass bit stops the loss-of-lock source from muting. If the request changes while a fade is running, the fade turns around at the step it has reached. The gain never jumps. A status output is raised only once the fade has reached silence.

Samples enter and leave on valid/ready handshakes. An input pair is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low with a pair pending, the pair and its `out_valid` stay frozen and no new input is taken. The ramp position moves only on accepted pairs.

Top module: `softmute`

## Requirements
- R1: With the ramp at full level, each accepted pair appears unchanged on the output one clock later. At any other ramp position k (0 = full, 32 = silent), each output is floor(sample × g(k) / 32768). Here g(k) = floor(16384 + 16384·cos(πk/32)), except that g(32) = 0. The same g(k) is used for both channels.
- R2: The mute request is the OR of `mute_pin`, `mute_reg` and the out-of-lock condition (`lock_ok` = 0). Each one alone starts a fade toward silence.
- R3: While `lock_bypass` = 1, `lock_ok` = 0 has no effect. The outputs keep equal to the inputs and `muted` stays 0.
- R4: While a request is held, each accepted pair uses the gain at the current position and then advances the position by one. The nth accepted pair (counting from 0) uses g(n), and from the 33rd pair on the output is 0.
- R5: Once the request is withdrawn, the positions are walked back one step per accepted pair through the same gains, until full level is reached.
- R6: A change of request in the middle of a fade reverses the direction from the position reached. The position never moves by more than one step per accepted pair.
- R7: `muted` is 1 exactly when the position is at silence (32), and 0 otherwise. While it is 1, accepted pairs leave as zeros.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, the outputs hold. Pairs that are not accepted move neither the output nor the ramp.
- R9: After reset `out_valid` is 0, `muted` is 0 and the ramp is at full level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Input pair can be taken |
| in_left | input | DATA_W | Left sample, signed |
| in_right | input | DATA_W | Right sample, signed |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the output pair |
| out_left | output | DATA_W | Scaled left sample, signed |
| out_right | output | DATA_W | Scaled right sample, signed |
| mute_pin | input | 1 | Mute request from the dedicated pin |
| mute_reg | input | 1 | Mute request from the control register |
| lock_ok | input | 1 | Input decoder reports lock |
| lock_bypass | input | 1 | 1 = loss of lock does not mute |
| muted | output | 1 | Fade has reached silence |

## Verification
The assertions assume that the request inputs may change on any cycle, but take effect only through accepted pairs. They also assume the consumer may stall indefinitely. The output-hold checks therefore reason only about cycles in which `out_ready` is low. The bench changes requests and stall conditions only at falling edges. It holds each offered pair steady until it is accepted, so that the handshake contract the properties rely on is kept. Gain values are compared against a real-valued cosine with a one-LSB allowance. At full level and at silence the comparison is exact.

// File: rtl/softmute_pkg.sv
package softmute_pkg;
  localparam int RAMP_LEN = 32;
  localparam int POS_W    = $clog2(RAMP_LEN + 1);
  localparam int GAIN_W   = 16;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [GAIN_W-1:0] gain_t;

  // raised-cosine gain, floor(16384 + 16384*cos(pi*k/32)); k = 32 is silence
  function automatic gain_t cos_gain(input pos_t k);
    case (k)
      6'd0:  return 16'd32768;
      6'd1:  return 16'd32689;
      6'd2:  return 16'd32453;
      6'd3:  return 16'd32062;
      6'd4:  return 16'd31520;
      6'd5:  return 16'd30833;
      6'd6:  return 16'd30006;
      6'd7:  return 16'd29049;
      6'd8:  return 16'd27969;
      6'd9:  return 16'd26777;
      6'd10: return 16'd25486;
      6'd11: return 16'd24107;
      6'd12: return 16'd22653;
      6'd13: return 16'd21140;
      6'd14: return 16'd19580;
      6'd15: return 16'd17989;
      6'd16: return 16'd16384;
      6'd17: return 16'd14778;
      6'd18: return 16'd13187;
      6'd19: return 16'd11627;
      6'd20: return 16'd10114;
      6'd21: return 16'd8660;
      6'd22: return 16'd7281;
      6'd23: return 16'd5990;
      6'd24: return 16'd4798;
      6'd25: return 16'd3718;
      6'd26: return 16'd2761;
      6'd27: return 16'd1934;
      6'd28: return 16'd1247;
      6'd29: return 16'd705;
      6'd30: return 16'd314;
      6'd31: return 16'd78;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/softmute_request.sv
module softmute_request (
  input  logic mute_pin,
  input  logic mute_reg,
  input  logic lock_ok,
  input  logic lock_bypass,
  output logic want_mute
);
  logic lock_lost;

  always_comb begin
    lock_lost = !lock_ok && !lock_bypass;
    want_mute = mute_pin || mute_reg || lock_lost;
  end
endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp
  import softmute_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic want_mute,
  output pos_t pos,
  output logic at_floor
);
  localparam pos_t FLOOR = pos_t'(RAMP_LEN);

  pos_t pos_nx;

  always_comb begin
    pos_nx = pos;
    if (want_mute) begin
      if (pos != FLOOR) pos_nx = pos + pos_t'(1);
    end else begin
      if (pos != '0) pos_nx = pos - pos_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= '0;
    else if (step_en) pos <= pos_nx;
  end

  assign at_floor = (pos == FLOOR);
endmodule

// File: rtl/softmute_scale.sv
module softmute_scale
  import softmute_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NCH    = 2
) (
  input  gain_t                        gain,
  input  logic [NCH-1:0][DATA_W-1:0]   samp_in,
  output logic [NCH-1:0][DATA_W-1:0]   samp_out
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam int FRAC_W = GAIN_W - 1;

  logic signed [GAIN_W:0] gain_s;
  assign gain_s = $signed({1'b0, gain});

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [PROD_W-1:0] prod;
    always_comb begin
      prod        = PROD_W'($signed(samp_in[c])) * PROD_W'(gain_s);
      samp_out[c] = DATA_W'(prod >>> FRAC_W);
    end
  end
endmodule

// File: rtl/softmute.sv
module softmute
  import softmute_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  input  logic              mute_pin,
  input  logic              mute_reg,
  input  logic              lock_ok,
  input  logic              lock_bypass,
  output logic              muted
);
  localparam int NCH = 2;

  logic                       want_mute;
  logic                       accept;
  pos_t                       ramp_pos;
  gain_t                      gain;
  logic [NCH-1:0][DATA_W-1:0] pair_in;
  logic [NCH-1:0][DATA_W-1:0] pair_scaled;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign pair_in  = {in_right, in_left};
  assign gain     = cos_gain(ramp_pos);

  softmute_request u_req (
    .mute_pin    (mute_pin),
    .mute_reg    (mute_reg),
    .lock_ok     (lock_ok),
    .lock_bypass (lock_bypass),
    .want_mute   (want_mute)
  );

  softmute_ramp u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (accept),
    .want_mute (want_mute),
    .pos       (ramp_pos),
    .at_floor  (muted)
  );

  softmute_scale #(.DATA_W(DATA_W), .NCH(NCH)) u_scale (
    .gain     (gain),
    .samp_in  (pair_in),
    .samp_out (pair_scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_left  <= pair_scaled[0];
      out_right <= pair_scaled[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/softmute_chk.sv
module softmute_chk
  import softmute_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_left,
  input logic [DATA_W-1:0] in_right,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              mute_pin,
  input logic              mute_reg,
  input logic              lock_ok,
  input logic              lock_bypass,
  input logic              muted,
  input pos_t              ramp_pos
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  // R8
  stall_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  silent_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && muted) |=> (out_left == '0 && out_right == '0));

  // R8
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(muted));

  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (ramp_pos == $past(ramp_pos) || ramp_pos == $past(ramp_pos) + pos_t'(1)
             || ramp_pos == $past(ramp_pos) - pos_t'(1)));

  // R3
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ramp_pos == '0 && !mute_pin && !mute_reg && (lock_ok || lock_bypass))
      |=> (out_left == $past(in_left) && out_right == $past(in_right)));
endmodule

bind softmute softmute_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_left     (in_left),
  .in_right    (in_right),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_left    (out_left),
  .out_right   (out_right),
  .mute_pin    (mute_pin),
  .mute_reg    (mute_reg),
  .lock_ok     (lock_ok),
  .lock_bypass (lock_bypass),
  .muted       (muted),
  .ramp_pos    (ramp_pos)
);

// File: tb/softmute_bench.sv
module softmute_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_left = '0;
  logic [DW-1:0] in_right = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_left, out_right;
  logic mute_pin = 1'b0, mute_reg = 1'b0, lock_ok = 1'b1, lock_bypass = 1'b0;
  logic muted;

  int total = 0;
  int bad = 0;
  int mpos = 0;
  bit done = 1'b0;

  softmute #(.DATA_W(DW)) u_softmute (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .mute_pin(mute_pin), .mute_reg(mute_reg), .lock_ok(lock_ok),
    .lock_bypass(lock_bypass), .muted(muted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint gain_ref(int p);
    real c;
    if (p >= 32) return 0;
    c = $cos(3.14159265358979323846 * p / 32.0);
    return longint'($floor(16384.0 + 16384.0 * c));
  endfunction

  function automatic int scale_ref(int s, int p);
    longint prod;
    prod = longint'(s) * gain_ref(p);
    return int'(prod >>> 15);
  endfunction

  task automatic check(string req, int act, int exp, int tol);
    int d;
    total++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offers one pair, waits for acceptance, then checks output and status
  task automatic send_one(string req, int l, int r);
    int el, er, tol;
    bit want;
    @(negedge clk);
    in_left  = DW'(l);
    in_right = DW'(r);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    want = mute_pin || mute_reg || (!lock_ok && !lock_bypass);
    el = scale_ref(l, mpos);
    er = scale_ref(r, mpos);
    tol = (mpos == 0 || mpos == 32) ? 0 : 1;
    if (want) begin if (mpos < 32) mpos++; end
    else begin if (mpos > 0) mpos--; end
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_valid"}, int'(out_valid), 1, 0);
    check({req, " left"}, int'($signed(out_left)), el, tol);
    check({req, " right"}, int'($signed(out_right)), er, tol);
    check({req, " R7 muted"}, int'(muted), (mpos == 32) ? 1 : 0, 0);
  endtask

  task automatic t_reset;
    check("R9 out_valid", int'(out_valid), 0, 0);
    check("R9 muted", int'(muted), 0, 0);
    check("R9 in_ready", int'(in_ready), 1, 0);
  endtask

  task automatic t_pass;
    send_one("R1 mid", 1000, -1000);
    send_one("R1 extremes", 32767, -32768);
    send_one("R1 small", 0, 5);
    send_one("R1 unit", -1, 1);
  endtask

  task automatic t_ramp_down;
    mute_pin = 1'b1;
    for (int i = 0; i < 34; i++) send_one("R4 fade", 20000, -20000);
    check("R7 muted after fade", int'(muted), 1, 0);
    check("R7 silent left", int'($signed(out_left)), 0, 0);
  endtask

  task automatic t_release;
    mute_pin = 1'b0;
    for (int i = 0; i < 33; i++) send_one("R5 unfade", -12345, 23456);
    check("R5 back at full", int'(muted), 0, 0);
    check("R5 full left", int'($signed(out_left)), -12345, 0);
  endtask

  task automatic t_reverse;
    mute_reg = 1'b1;
    for (int i = 0; i < 10; i++) send_one("R2 reg fade", 30000, 30000);
    mute_reg = 1'b0;
    for (int i = 0; i < 10; i++) send_one("R6 turnaround", 30000, -30000);
    check("R6 returned to full", int'($signed(out_left)), scale_ref(30000, 1), 1);
    send_one("R6 full again", 777, -777);
  endtask

  task automatic t_lock;
    lock_ok = 1'b0;
    for (int i = 0; i < 32; i++) send_one("R2 lock fade", 16000, -8000);
    check("R2 lock muted", int'(muted), 1, 0);
    lock_ok = 1'b1;
    for (int i = 0; i < 33; i++) send_one("R5 lock regain", 16000, -8000);
  endtask

  task automatic t_bypass;
    lock_bypass = 1'b1;
    lock_ok = 1'b0;
    for (int i = 0; i < 40; i++) send_one("R3 bypass", 4000 + i, -4000 - i);
    check("R3 not muted", int'(muted), 0, 0);
    check("R3 pass left", int'($signed(out_left)), 4039, 0);
    lock_ok = 1'b1;
    lock_bypass = 1'b0;
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    send_one("R8 first", 1111, -2222);
    @(negedge clk);
    in_left  = DW'(3333);
    in_right = DW'(-4444);
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 not ready", int'(in_ready), 0, 0);
      check("R8 held left", int'($signed(out_left)), 1111, 0);
      check("R8 held valid", int'(out_valid), 1, 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    if (mpos > 0) mpos--;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second left", int'($signed(out_left)), 3333, 0);
    check("R8 second right", int'($signed(out_right)), -4444, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_ramp_down();
    t_release();
    t_reverse();
    t_lock();
    t_bypass();
    t_stall();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule